// File: doc/BRIEF.md
# Direct Bit Manipulation Unit

This unit performs single-bit operations on a byte-wide, 256-entry data space. A bit instruction takes two words. The first is an opcode word that holds a 3-bit bit index and an operation code. The second is the absolute byte address, which the unit fetches itself through an address-word handshake once it has accepted the opcode word.

The write operations force the selected bit to 1 or 0, or copy the Z or V status flag into it. Each one is a read-modify-write of the addressed byte, and the other seven bits keep their values. The test operations only read the byte. They report whether the selected bit matches the tested polarity, and the skip logic of the surrounding core uses that result. The unit never changes a status flag and has no register-computed bit addressing.

The data-memory port is synchronous: read data appears one cycle after the address. A write operation with an address word that is already available completes in five cycles. A new start can be accepted in the same cycle that done is high, so operations can run back to back.

Top module: `bitop_unit`

## Requirements
- R1: While rst_n is low, and in the cycle after it is released, busy, done, aw_req, dm_we and test_true are all low. A reset that arrives during an operation abandons it, and no write is issued.
- R2: op_word[2:0] is the bit index (0 to 7). op_word[5:3] is the operation code: 0 sets the bit, 1 clears it, 2 writes Z into it, 3 writes V into it, 4 tests for set, 5 tests for clear, and 6 and 7 are reserved.
- R3: After a start is accepted, aw_req is high from the next cycle until aw_valid is seen. aw_data is captured in that cycle and becomes the read address. An aw_valid outside this phase is ignored.
- R4: Set and clear issue exactly one write, to the captured address. Only the selected bit changes, and no other address is written.
- R5: Write-Z and write-V store the flag value present in the cycle the start was accepted. Later changes to z_flag or v_flag have no effect on that operation.
- R6: A test operation never asserts dm_we. With done it drives test_true to 1 exactly when the selected bit equals 1 (test-set) or 0 (test-clear). Every non-test operation gives test_true = 0.
- R7: Reserved codes read the byte and then finish with done. They write nothing and report test_true = 0.
- R8: done is high for exactly one cycle. A start in that cycle is accepted at once, and that next operation sees the byte just written.
- R9: A start while busy is high has no effect: the running operation finishes normally and the unit is idle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin an operation using op_word |
| op_word | input | 6 | Bit index [2:0] and operation code [5:3] |
| z_flag | input | 1 | Current Z status flag |
| v_flag | input | 1 | Current V status flag |
| aw_req | output | 1 | Unit is waiting for the address word |
| aw_valid | input | 1 | aw_data holds the address word |
| aw_data | input | 8 | Absolute byte address |
| dm_addr | output | 8 | Data-memory address |
| dm_rdata | input | 8 | Data-memory read data, one cycle after dm_addr |
| dm_wdata | output | 8 | Data-memory write data |
| dm_we | output | 1 | Data-memory write enable |
| busy | output | 1 | Operation in progress; start is ignored |
| done | output | 1 | One-cycle completion pulse |
| test_true | output | 1 | Test result, valid with done |

## Verification
Completion and acceptance can happen in the same cycle. The bench raises start in the cycle where done is high, right after a set of bit 1. It then checks that aw_req rises on the next cycle and that the following test-set reads the byte that was just written and reports true. The bench also raises start while the unit is in its read phase. There it checks that exactly one write and one done appear, that the byte holds only the first operation's result, and that the unit is idle afterwards.

// File: rtl/bitop_pkg.sv
// Package bitop_pkg
// Shared types for the bit manipulation unit: operation codes, the
// sequencer states and the decoded control bundle.
// Assumes the op code field is three bits wide.
package bitop_pkg;

    // Operation codes carried in the opcode word
    typedef enum logic [2:0] {
        OP_SET  = 3'd0,
        OP_CLR  = 3'd1,
        OP_PUTZ = 3'd2,
        OP_PUTV = 3'd3,
        OP_TSET = 3'd4,
        OP_TCLR = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } bop_e;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_READ  = 3'd2,
        ST_MOD   = 3'd3,
        ST_WRITE = 3'd4,
        ST_FIN   = 3'd5
    } bst_e;

    // Source of the value written into the selected bit
    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_ONE  = 2'd1,
        SRC_Z    = 2'd2,
        SRC_V    = 2'd3
    } bsrc_e;

    // Decoded control for one operation
    typedef struct packed {
        logic  wr;    // operation writes the byte back
        logic  tst;   // operation reports a test result
        logic  tpol;  // test is true when the bit equals this value
        bsrc_e src;   // value placed into the bit on a write
    } bctl_t;

endpackage

// File: rtl/bitop_decode.sv
// Module bitop_decode
// Splits the opcode word into a bit index and a control bundle.
// Purely combinational. Reserved codes decode to "read only, no test".
// Assumes op_word[IW-1:0] is the index and op_word[IW+2:IW] is the code.
module bitop_decode
    import bitop_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic [IW+2:0] op_word,
    output logic [IW-1:0] idx,
    output bctl_t         ctl
);

    bop_e code;

    assign idx  = op_word[IW-1:0];
    assign code = bop_e'(op_word[IW+2:IW]);

    // Map the operation code to its control bundle
    always_comb begin
        ctl = '{wr: 1'b0, tst: 1'b0, tpol: 1'b0, src: SRC_ZERO};
        case (code)
            OP_SET:  begin ctl.wr = 1'b1; ctl.src = SRC_ONE;  end
            OP_CLR:  begin ctl.wr = 1'b1; ctl.src = SRC_ZERO; end
            OP_PUTZ: begin ctl.wr = 1'b1; ctl.src = SRC_Z;    end
            OP_PUTV: begin ctl.wr = 1'b1; ctl.src = SRC_V;    end
            OP_TSET: begin ctl.tst = 1'b1; ctl.tpol = 1'b1;   end
            OP_TCLR: begin ctl.tst = 1'b1; ctl.tpol = 1'b0;   end
            default: ctl = '{wr: 1'b0, tst: 1'b0, tpol: 1'b0, src: SRC_ZERO};
        endcase
    end

endmodule

// File: rtl/bitop_alu.sv
// Module bitop_alu
// Replaces one bit of a byte and extracts the same bit for testing.
// Combinational. One multiplexer per bit lane, built with generate.
// Assumes idx < DW.
module bitop_alu #(
    parameter int DW = 8,
    localparam int IW = $clog2(DW)
) (
    input  logic [DW-1:0] rd_byte,
    input  logic [IW-1:0] idx,
    input  logic          new_bit,
    output logic [DW-1:0] wr_byte,
    output logic          sel_bit
);

    // One lane per bit: take new_bit in the selected lane, else keep the old bit
    for (genvar g = 0; g < DW; g++) begin : g_lane
        assign wr_byte[g] = (idx == IW'(g)) ? new_bit : rd_byte[g];
    end

    // Bit under test
    assign sel_bit = rd_byte[idx];

endmodule

// File: rtl/bitop_fsm.sv
// Module bitop_fsm
// Sequencer: idle -> fetch address word -> read -> modify -> (write) -> finish.
// A start is taken in idle or in the finish cycle, which allows back-to-back
// operations. Assumes data-memory read data arrives one cycle after the address.
module bitop_fsm
    import bitop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic aw_valid,
    input  logic wr_op,
    output bst_e state,
    output logic accept
);

    bst_e nxt;

    // Start is taken when idle or when the previous operation is finishing
    assign accept = start && ((state == ST_IDLE) || (state == ST_FIN));

    // Next-state selection
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  nxt = accept ? ST_FETCH : ST_IDLE;
            ST_FETCH: nxt = aw_valid ? ST_READ : ST_FETCH;
            ST_READ:  nxt = ST_MOD;
            ST_MOD:   nxt = wr_op ? ST_WRITE : ST_FIN;
            ST_WRITE: nxt = ST_FIN;
            ST_FIN:   nxt = accept ? ST_FETCH : ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

endmodule

// File: rtl/bitop_unit.sv
// Module bitop_unit (top)
// Direct bit manipulation unit. It fetches an absolute address word, reads
// the byte, and either writes it back with one bit replaced (set, clear,
// Z, V) or reports a bit test. Status flags are sampled when the start is
// accepted and are never modified. Assumes a synchronous data memory with
// one cycle of read latency.
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 8,
    localparam int IW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW+2:0] op_word,
    input  logic          z_flag,
    input  logic          v_flag,
    output logic          aw_req,
    input  logic          aw_valid,
    input  logic [AW-1:0] aw_data,
    output logic [AW-1:0] dm_addr,
    input  logic [DW-1:0] dm_rdata,
    output logic [DW-1:0] dm_wdata,
    output logic          dm_we,
    output logic          busy,
    output logic          done,
    output logic          test_true
);

    bst_e          state;
    logic          accept;
    logic [IW-1:0] dec_idx;
    bctl_t         dec_ctl;

    logic [IW-1:0] idx_q;
    bctl_t         ctl_q;
    logic          z_q, v_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wbyte_q;
    logic          tres_q;
    logic          wr_q;

    logic          new_bit;
    logic [DW-1:0] mod_byte;
    logic          sel_bit;

    bitop_decode #(.IW(IW)) u_dec (
        .op_word (op_word),
        .idx     (dec_idx),
        .ctl     (dec_ctl)
    );

    bitop_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .aw_valid (aw_valid),
        .wr_op    (ctl_q.wr),
        .state    (state),
        .accept   (accept)
    );

    bitop_alu #(.DW(DW)) u_alu (
        .rd_byte (dm_rdata),
        .idx     (idx_q),
        .new_bit (new_bit),
        .wr_byte (mod_byte),
        .sel_bit (sel_bit)
    );

    // Value to place into the selected bit
    always_comb begin
        case (ctl_q.src)
            SRC_ONE: new_bit = 1'b1;
            SRC_Z:   new_bit = z_q;
            SRC_V:   new_bit = v_q;
            default: new_bit = 1'b0;
        endcase
    end

    // Capture the operation and the flags when a start is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            ctl_q <= '{wr: 1'b0, tst: 1'b0, tpol: 1'b0, src: SRC_ZERO};
            z_q   <= 1'b0;
            v_q   <= 1'b0;
        end else if (accept) begin
            idx_q <= dec_idx;
            ctl_q <= dec_ctl;
            z_q   <= z_flag;
            v_q   <= v_flag;
        end
    end

    // Capture the address word during the fetch phase
    always_ff @(posedge clk) begin
        if (!rst_n)                              addr_q <= '0;
        else if (state == ST_FETCH && aw_valid) addr_q <= aw_data;
    end

    // Capture the modified byte and the test result in the modify phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbyte_q <= '0;
            tres_q  <= 1'b0;
        end else if (state == ST_MOD) begin
            wbyte_q <= mod_byte;
            tres_q  <= ctl_q.tst & (sel_bit == ctl_q.tpol);
        end
    end

    // Write intent of the operation in flight, seen by the checker
    assign wr_q = ctl_q.wr;

    // Port drive
    assign aw_req    = (state == ST_FETCH);
    assign dm_addr   = addr_q;
    assign dm_wdata  = wbyte_q;
    assign dm_we     = (state == ST_WRITE);
    assign done      = (state == ST_FIN);
    assign busy      = (state != ST_IDLE) && (state != ST_FIN);
    assign test_true = done & tres_q;

endmodule

// File: rtl/bitop_unit_chk.sv
// Module bitop_unit_chk
// Protocol checker for bitop_unit, attached with bind.
// Assumes the synchronous active-low reset of the unit.
module bitop_unit_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          dm_we,
    input logic          aw_req,
    input logic          aw_valid,
    input logic [AW-1:0] dm_addr,
    input logic          wr_q
);

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: a write is single and is followed at once by completion
    p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |=> (!dm_we && done));

    // R4: the write address is the one that was read
    p_we_addr_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |-> $stable(dm_addr));

    // R6: only operations decoded as writes may write
    p_we_only_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |-> wr_q);

    // R3: the address request holds until the word arrives
    p_aw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_req && !aw_valid) |=> aw_req);

    // R3: no write or completion while the address word is awaited
    p_fetch_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        aw_req |-> (!dm_we && !done));

endmodule

bind bitop_unit bitop_unit_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .dm_we    (dm_we),
    .aw_req   (aw_req),
    .aw_valid (aw_valid),
    .dm_addr  (dm_addr),
    .wr_q     (wr_q)
);

// File: tb/bitop_unit_tb.sv
`timescale 1ns/1ps
module bitop_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [5:0] op_word = '0;
    logic       z_flag = 1'b0;
    logic       v_flag = 1'b0;
    logic       aw_valid = 1'b0;
    logic [7:0] aw_data = '0;
    logic       aw_req, dm_we, busy, done, test_true;
    logic [7:0] dm_addr, dm_rdata, dm_wdata;

    int checks = 0;
    int errors = 0;

    // Memory model: synchronous read, plus a preload port used by the bench
    logic [7:0] mem [256];
    logic       pre_we = 1'b0;
    logic [7:0] pre_addr = '0, pre_data = '0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (pre_we)     mem[pre_addr] <= pre_data;
        else if (dm_we) mem[dm_addr]  <= dm_wdata;
        dm_rdata <= mem[dm_addr];
    end

    bitop_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_word(op_word),
        .z_flag(z_flag), .v_flag(v_flag), .aw_req(aw_req), .aw_valid(aw_valid),
        .aw_data(aw_data), .dm_addr(dm_addr), .dm_rdata(dm_rdata),
        .dm_wdata(dm_wdata), .dm_we(dm_we), .busy(busy), .done(done),
        .test_true(test_true)
    );

    // Vectors: op_word(6) addr(8) {z,v}(2) init(8) expected byte(8) test_true(1) writes(1)
    // Codes per R2: 0 set, 1 clear, 2 Z, 3 V, 4 test-set, 5 test-clear, 6/7 reserved
    localparam int NV = 14;
    localparam logic [33:0] VEC [NV] = '{
        {6'h00, 8'h10, 2'b00, 8'h00, 8'h01, 1'b0, 1'b1},
        {6'h07, 8'hFF, 2'b00, 8'h7F, 8'hFF, 1'b0, 1'b1},
        {6'h0B, 8'h20, 2'b11, 8'hFF, 8'hF7, 1'b0, 1'b1},
        {6'h0D, 8'h21, 2'b00, 8'h00, 8'h00, 1'b0, 1'b1},
        {6'h12, 8'h30, 2'b10, 8'hA0, 8'hA4, 1'b0, 1'b1},
        {6'h17, 8'h31, 2'b01, 8'hA5, 8'h25, 1'b0, 1'b1},
        {6'h1E, 8'h32, 2'b01, 8'h00, 8'h40, 1'b0, 1'b1},
        {6'h19, 8'h00, 2'b10, 8'hFF, 8'hFD, 1'b0, 1'b1},
        {6'h24, 8'h40, 2'b00, 8'h10, 8'h10, 1'b1, 1'b0},
        {6'h24, 8'h41, 2'b11, 8'hEF, 8'hEF, 1'b0, 1'b0},
        {6'h28, 8'h42, 2'b00, 8'hFE, 8'hFE, 1'b1, 1'b0},
        {6'h28, 8'h43, 2'b00, 8'h01, 8'h01, 1'b0, 1'b0},
        {6'h32, 8'h44, 2'b00, 8'h5A, 8'h5A, 1'b0, 1'b0},
        {6'h3F, 8'h45, 2'b11, 8'h80, 8'h80, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic preload(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); pre_we = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk); pre_we = 1'b0;
    endtask

    // Wait for done from the read phase; count writes and capture test_true
    task automatic finish_op(input logic [7:0] adr, input bit poke,
                             output logic tt, output int wecnt);
        bit seen = 0;
        wecnt = 0; tt = 1'b0;
        if (poke) begin start = 1'b1; op_word = 6'h00; end
        for (int c = 0; c < 12; c++) begin
            if (dm_we) begin
                wecnt++;
                chk("R4", "write address", 32'(dm_addr), 32'(adr));
            end
            if (done) begin tt = test_true; seen = 1; break; end
            @(negedge clk); start = 1'b0;
        end
        chk("R8", "done seen", 32'(seen), 32'd1);
    endtask

    // Issue one operation; the flags are inverted after acceptance (R5)
    task automatic run_op(input logic [5:0] opw, input logic [7:0] adr,
                          input logic z, input logic v, input bit slow_aw,
                          input bit poke, output logic tt, output int wecnt);
        @(negedge clk); start = 1'b1; op_word = opw; z_flag = z; v_flag = v;
        @(negedge clk); start = 1'b0; z_flag = ~z; v_flag = ~v;
        chk("R3", "aw_req after accept", 32'(aw_req), 32'd1);
        if (slow_aw) begin
            @(negedge clk);
            chk("R3", "aw_req held", 32'(aw_req), 32'd1);
        end
        aw_valid = 1'b1; aw_data = adr;
        @(negedge clk); aw_valid = 1'b0; aw_data = ~adr;
        chk("R3", "read address", 32'(dm_addr), 32'(adr));
        finish_op(adr, poke, tt, wecnt);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [5:0] opw;
        logic [7:0] adr, init, expb;
        logic [1:0] zv;
        logic       expt, expw, tt;
        int         wecnt;
        string      req;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "done", 32'(done), 0);
        chk("R1", "aw_req", 32'(aw_req), 0);
        chk("R1", "dm_we", 32'(dm_we), 0);
        chk("R1", "test_true", 32'(test_true), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after release", 32'({busy, done, aw_req, dm_we}), 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            {opw, adr, zv, init, expb, expt, expw} = VEC[i];
            preload(adr, init);
            preload(adr + 8'd1, 8'h3C);
            run_op(opw, adr, zv[1], zv[0], (i % 2) == 1, 1'b0, tt, wecnt);
            case (opw[5:3])
                3'd0, 3'd1: req = "R4";
                3'd2, 3'd3: req = "R5";
                3'd4, 3'd5: req = "R6";
                default:    req = "R7";
            endcase
            chk(req, "byte", 32'(mem[adr]), 32'(expb));
            chk("R4", "neighbour byte", 32'(mem[adr + 8'd1]), 32'h3C);
            chk(req, "test_true", 32'(tt), 32'(expt));
            chk("R2", "write count", 32'(wecnt), 32'(expw));
            @(negedge clk);
            chk("R8", "done one cycle", 32'(done), 0);
        end

        // R8: start in the done cycle, next op reads the new byte
        preload(8'h50, 8'h00);
        run_op(6'h01, 8'h50, 1'b0, 1'b0, 1'b0, 1'b0, tt, wecnt);
        start = 1'b1; op_word = 6'h21;
        @(negedge clk); start = 1'b0;
        chk("R8", "back-to-back accept", 32'(aw_req), 32'd1);
        aw_valid = 1'b1; aw_data = 8'h50;
        @(negedge clk); aw_valid = 1'b0;
        finish_op(8'h50, 1'b0, tt, wecnt);
        chk("R8", "test sees written byte", 32'(tt), 32'd1);
        chk("R8", "byte after set", 32'(mem[8'h50]), 32'h02);
        chk("R8", "no write for test", 32'(wecnt), 0);

        // R9: start while busy is ignored
        preload(8'h60, 8'hFF);
        run_op(6'h08, 8'h60, 1'b0, 1'b0, 1'b0, 1'b1, tt, wecnt);
        chk("R9", "single write", 32'(wecnt), 32'd1);
        chk("R9", "byte after clear", 32'(mem[8'h60]), 32'hFE);
        @(negedge clk);
        chk("R9", "idle afterwards", 32'({busy, aw_req, done}), 0);

        // R1: reset during fetch abandons the operation
        preload(8'h70, 8'h00);
        @(negedge clk); start = 1'b1; op_word = 6'h00;
        @(negedge clk); start = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1", "abandoned op idle", 32'({busy, aw_req, dm_we}), 0);

        // R3: aw_valid while idle is ignored
        aw_valid = 1'b1; aw_data = 8'h70;
        repeat (3) begin
            @(negedge clk);
            chk("R3", "stray aw_valid", 32'({busy, aw_req, dm_we, done}), 0);
        end
        aw_valid = 1'b0;
        chk("R1", "no write after reset", 32'(mem[8'h70]), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule